// File: doc/BRIEF.md
# Stack Bytecode Instruction Window Decoder

The block receives instruction bytes one per cycle from the fetch side and holds them in a small shifting window. It assembles the head of the window into a complete variable-length stack-machine bytecode of one to three bytes. This may be a plain opcode, an opcode followed by operand bytes, or a two-byte form behind the 0xFF escape. The decoder translates that bytecode into an 8-bit internal opcode whose upper nibble names the functional group. It then consumes those bytes from the window.

Each issued instruction carries four things besides the internal opcode. The first is a 16-bit immediate. The second is a base-register select and offset, so the stack memory can read all operands in the following cycle. The third is the byte address of the instruction. The fourth is an illegal flag for bytes the translator does not know. Array accesses are not issued directly. The decoder sends a request with a microcode address to a sequencer and holds decode until the sequencer reports completion. A window-full flag tells fetch to stop supplying bytes.

Top module: `bcode_window_dec`

## Requirements
- R1: After reset, `insn_valid`, `insn_illegal`, `ucode_req` and `win_full` are all low, and the window holds no bytes.
- R2: Arithmetic and logic bytecodes translate as follows: 0x60→0x30, 0x64→0x31, 0x68→0x34, 0x6C→0x35, 0x7A→0x32, 0x74→0xC0, 0x78→0xC1, 0x7E→0xC3, 0x80→0xC4, 0x82→0xC5. The duplicate bytecode 0x59 translates to 0x11. All of these are one byte long.
- R3: Constant pushes translate to 0x40 with base select 0 and offset 0. 0x01 gives immediate 0, and 0x02..0x08 give -1..5 as 16-bit two's complement. 0x10 takes one operand byte, which is sign-extended. 0x11 takes two operand bytes, high byte first.
- R4: Local loads translate to 0x10 and local stores to 0x20, both with base select 1 (local frame). The local index goes in the offset. For 0x15, 0x19, 0x36 and 0x3A the index is the following byte. For 0x1A..0x1D, 0x2A..0x2D, 0x3B..0x3E and 0x4B..0x4E the index is the low distance from the first code of each run.
- R5: The three-byte branches translate as follows: 0x99→0x50, 0x9B→0x59, 0x9F→0xA0, 0xA1→0xA9. The two following bytes form the immediate, high byte first.
- R6: Byte 0xFF starts a two-byte instruction selected by its second byte: 0x04→0x11, 0x24→0x21, 0x40→0xF0, 0x43→0xF1.
- R7: Bytecode 0x2E or 0x4F raises `ucode_req` for exactly one cycle, with `ucode_addr` set to parameter `UC_ADDR_ALOAD` or `UC_ADDR_ASTORE`. It issues no instruction. No further instruction issues until `ucode_done` is seen.
- R8: Any unlisted first byte is consumed as a one-byte instruction. Any unlisted second byte after 0xFF is consumed as two bytes. Either case issues one output with opcode 0x00, immediate 0, base 0, offset 0 and `insn_illegal` high in that cycle.
- R9: `insn_pc` is the byte address of the instruction's first byte. Addresses count from 0 after reset and advance by each consumed length.
- R10: Decode waits while the window holds fewer bytes than the head instruction needs. An instruction issues in the cycle after its last byte is accepted.
- R11: `win_full` is high exactly when the window holds `DEPTH` bytes. No byte is accepted while it is high.
- R12: Stack-operand reads use base select 2 (operand stack top). The offset is 1 for two-operand instructions (binary arithmetic and logic, 0x9F, 0xA1, 0xFF 0x24). The offset is 0 for one-operand instructions (0x74, 0x59, 0x99, 0x9B, 0xFF 0x04). Opcodes 0xF0 and 0xF1 use base select 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_valid | input | 1 | A byte is offered on `fetch_byte` |
| fetch_byte | input | 8 | Instruction byte from fetch |
| win_full | output | 1 | Window holds DEPTH bytes; fetch must hold off |
| ucode_done | input | 1 | Microcode sequencer finished the current request |
| ucode_req | output | 1 | One-cycle microcode request |
| ucode_addr | output | UA_W | Microcode entry address for the request |
| insn_valid | output | 1 | An instruction is issued this cycle |
| insn_op | output | 8 | Internal opcode, group in the upper nibble |
| insn_imm | output | 16 | Immediate value or branch displacement |
| insn_base | output | 2 | Operand-fetch base select: 0 none, 1 local frame, 2 stack top |
| insn_offset | output | 8 | Operand-fetch offset from the selected base |
| insn_pc | output | PC_W | Byte address of the issued instruction |
| insn_illegal | output | 1 | Issued instruction came from an unknown bytecode |

## Verification
Several behaviours are checked by the embedded assertions on every cycle. These include the window occupancy bound, the rule that never more bytes are consumed than are held, and a full window staying full while nothing drains. They also check that a microcode request lasts one cycle, never coincides with an issue, and holds the wait state until completion, and that every illegal issue is a bare no-operation. Other behaviours only show up in the bench's scenarios. These are the translation tables, the immediate and index extraction, the instruction addresses, the decode wait when operand bytes trickle in with gaps, and the window filling to full during a microcode stall without losing a byte.

// File: rtl/bcw_pkg.sv
package bcw_pkg;

  typedef enum logic [1:0] {
    K_ISSUE   = 2'd0,
    K_UCODE   = 2'd1,
    K_ILLEGAL = 2'd2
  } bcw_kind_e;

  localparam logic [1:0] SEL_NONE  = 2'd0;
  localparam logic [1:0] SEL_FRAME = 2'd1;
  localparam logic [1:0] SEL_TOS   = 2'd2;

  localparam logic [7:0] IOP_NOP    = 8'h00;
  localparam logic [7:0] IOP_PUSH   = 8'h40;
  localparam logic [7:0] IOP_LOADV  = 8'h10;
  localparam logic [7:0] IOP_LOADO  = 8'h11;
  localparam logic [7:0] IOP_STOREV = 8'h20;
  localparam logic [7:0] IOP_STOREW = 8'h21;
  localparam logic [7:0] IOP_RDPC   = 8'hF0;
  localparam logic [7:0] IOP_RDTOS  = 8'hF1;

  localparam logic [7:0] ESCAPE_BYTE = 8'hFF;

  typedef enum logic [0:0] {
    ST_RUN  = 1'b0,
    ST_WAIT = 1'b1
  } bcw_state_e;

endpackage

// File: rtl/bcw_window.sv
module bcw_window #(
  parameter int DEPTH = 8,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_en,
  input  logic [7:0]    push_byte,
  input  logic [1:0]    pop_len,
  output logic [7:0]    head0,
  output logic [7:0]    head1,
  output logic [7:0]    head2,
  output logic [CW-1:0] count,
  output logic          full
);

  localparam int EXT = DEPTH + 3;

  logic [7:0]    slot_q   [DEPTH];
  logic [7:0]    slot_nxt [DEPTH];
  logic [7:0]    ext      [EXT];
  logic [CW-1:0] count_q, count_nxt, kept;
  logic          slot_en;

  // zero-padded view so a shift of up to three never indexes outside
  for (genvar gx = 0; gx < EXT; gx++) begin : g_ext
    if (gx < DEPTH) begin : g_real
      assign ext[gx] = slot_q[gx];
    end else begin : g_pad
      assign ext[gx] = 8'h00;
    end
  end

  assign kept    = count_q - CW'(pop_len);
  assign slot_en = push_en || (pop_len != 2'd0);

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
    always_comb begin
      unique case (pop_len)
        2'd0:    slot_nxt[gi] = ext[gi];
        2'd1:    slot_nxt[gi] = ext[gi + 1];
        2'd2:    slot_nxt[gi] = ext[gi + 2];
        default: slot_nxt[gi] = ext[gi + 3];
      endcase
      if (push_en && (CW'(gi) == kept)) begin
        slot_nxt[gi] = push_byte;
      end
    end

    always_ff @(posedge clk) begin
      if (slot_en) begin
        slot_q[gi] <= slot_nxt[gi];
      end
    end
  end

  always_comb begin
    count_nxt = kept + CW'(push_en);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else begin
      count_q <= count_nxt;
    end
  end

  assign head0 = slot_q[0];
  assign head1 = slot_q[1];
  assign head2 = slot_q[2];
  assign count = count_q;
  assign full  = (count_q == CW'(DEPTH));

  assert_count_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CW'(DEPTH));

  assert_pop_le_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
    CW'(pop_len) <= count_q);

  assert_full_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (full && pop_len == 2'd0) |=> full);

endmodule

// File: rtl/bcw_xlate.sv
module bcw_xlate
  import bcw_pkg::*;
#(
  parameter int                 UA_W           = 8,
  parameter logic [UA_W-1:0]    UC_ADDR_ALOAD  = 'h10,
  parameter logic [UA_W-1:0]    UC_ADDR_ASTORE = 'h20
) (
  input  logic [7:0]      b0,
  input  logic [7:0]      b1,
  input  logic [7:0]      b2,
  output logic [1:0]      len,
  output bcw_kind_e       kind,
  output logic [7:0]      op,
  output logic [15:0]     imm,
  output logic [1:0]      base,
  output logic [7:0]      offset,
  output logic [UA_W-1:0] uaddr
);

  always_comb begin
    len    = 2'd1;
    kind   = K_ISSUE;
    op     = IOP_NOP;
    imm    = 16'h0000;
    base   = SEL_NONE;
    offset = 8'h00;
    uaddr  = '0;

    case (b0) inside
      // constant and immediate pushes
      8'h01: op = IOP_PUSH;
      [8'h02:8'h08]: begin
        op  = IOP_PUSH;
        imm = {8'h00, b0} - 16'd3;
      end
      8'h10: begin
        op  = IOP_PUSH;
        len = 2'd2;
        imm = {{8{b1[7]}}, b1};
      end
      8'h11: begin
        op  = IOP_PUSH;
        len = 2'd3;
        imm = {b1, b2};
      end
      // local variable loads
      8'h15, 8'h19: begin
        op = IOP_LOADV; len = 2'd2; base = SEL_FRAME; offset = b1;
      end
      [8'h1A:8'h1D]: begin
        op = IOP_LOADV; base = SEL_FRAME; offset = b0 - 8'h1A;
      end
      [8'h2A:8'h2D]: begin
        op = IOP_LOADV; base = SEL_FRAME; offset = b0 - 8'h2A;
      end
      // local variable stores
      8'h36, 8'h3A: begin
        op = IOP_STOREV; len = 2'd2; base = SEL_FRAME; offset = b1;
      end
      [8'h3B:8'h3E]: begin
        op = IOP_STOREV; base = SEL_FRAME; offset = b0 - 8'h3B;
      end
      [8'h4B:8'h4E]: begin
        op = IOP_STOREV; base = SEL_FRAME; offset = b0 - 8'h4B;
      end
      // array accesses go to the microcode sequencer
      8'h2E: begin kind = K_UCODE; uaddr = UC_ADDR_ALOAD;  end
      8'h4F: begin kind = K_UCODE; uaddr = UC_ADDR_ASTORE; end
      // single-operand stack reads
      8'h59: begin op = IOP_LOADO; base = SEL_TOS; end
      8'h74: begin op = 8'hC0;     base = SEL_TOS; end
      // two-operand arithmetic and logic
      8'h60: begin op = 8'h30; base = SEL_TOS; offset = 8'd1; end
      8'h64: begin op = 8'h31; base = SEL_TOS; offset = 8'd1; end
      8'h68: begin op = 8'h34; base = SEL_TOS; offset = 8'd1; end
      8'h6C: begin op = 8'h35; base = SEL_TOS; offset = 8'd1; end
      8'h7A: begin op = 8'h32; base = SEL_TOS; offset = 8'd1; end
      8'h78: begin op = 8'hC1; base = SEL_TOS; offset = 8'd1; end
      8'h7E: begin op = 8'hC3; base = SEL_TOS; offset = 8'd1; end
      8'h80: begin op = 8'hC4; base = SEL_TOS; offset = 8'd1; end
      8'h82: begin op = 8'hC5; base = SEL_TOS; offset = 8'd1; end
      // branches with a 16-bit displacement
      8'h99: begin op = 8'h50; len = 2'd3; imm = {b1, b2}; base = SEL_TOS; end
      8'h9B: begin op = 8'h59; len = 2'd3; imm = {b1, b2}; base = SEL_TOS; end
      8'h9F: begin
        op = 8'hA0; len = 2'd3; imm = {b1, b2}; base = SEL_TOS; offset = 8'd1;
      end
      8'hA1: begin
        op = 8'hA9; len = 2'd3; imm = {b1, b2}; base = SEL_TOS; offset = 8'd1;
      end
      // escaped two-byte forms
      ESCAPE_BYTE: begin
        len = 2'd2;
        unique case (b1)
          8'h04: begin op = IOP_LOADO;  base = SEL_TOS; end
          8'h24: begin op = IOP_STOREW; base = SEL_TOS; offset = 8'd1; end
          8'h40: op = IOP_RDPC;
          8'h43: op = IOP_RDTOS;
          default: kind = K_ILLEGAL;
        endcase
      end
      default: kind = K_ILLEGAL;
    endcase
  end

endmodule

// File: rtl/bcode_window_dec.sv
module bcode_window_dec
  import bcw_pkg::*;
#(
  parameter int              DEPTH          = 8,
  parameter int              PC_W           = 16,
  parameter int              UA_W           = 8,
  parameter logic [UA_W-1:0] UC_ADDR_ALOAD  = 'h10,
  parameter logic [UA_W-1:0] UC_ADDR_ASTORE = 'h20
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fetch_valid,
  input  logic [7:0]      fetch_byte,
  output logic            win_full,
  input  logic            ucode_done,
  output logic            ucode_req,
  output logic [UA_W-1:0] ucode_addr,
  output logic            insn_valid,
  output logic [7:0]      insn_op,
  output logic [15:0]     insn_imm,
  output logic [1:0]      insn_base,
  output logic [7:0]      insn_offset,
  output logic [PC_W-1:0] insn_pc,
  output logic            insn_illegal
);

  localparam int CW = $clog2(DEPTH + 1);

  logic [7:0]      h0, h1, h2;
  logic [CW-1:0]   held;
  logic            full;
  logic            accept;
  logic [1:0]      pop_len;

  logic [1:0]      dec_len;
  bcw_kind_e       dec_kind;
  logic [7:0]      dec_op;
  logic [15:0]     dec_imm;
  logic [1:0]      dec_base;
  logic [7:0]      dec_off;
  logic [UA_W-1:0] dec_uaddr;

  bcw_state_e      state_q, state_nxt;
  logic            fire;
  logic [PC_W-1:0] pc_q, pc_nxt;

  logic            valid_q, illegal_q, ureq_q;
  logic            valid_nxt, illegal_nxt, ureq_nxt;
  logic [7:0]      op_q;
  logic [15:0]     imm_q;
  logic [1:0]      base_q;
  logic [7:0]      off_q;
  logic [PC_W-1:0] ipc_q;
  logic [UA_W-1:0] uaddr_q;

  assign accept = fetch_valid && !full;

  bcw_window #(.DEPTH(DEPTH), .CW(CW)) u_window (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_en   (accept),
    .push_byte (fetch_byte),
    .pop_len   (pop_len),
    .head0     (h0),
    .head1     (h1),
    .head2     (h2),
    .count     (held),
    .full      (full)
  );

  bcw_xlate #(
    .UA_W           (UA_W),
    .UC_ADDR_ALOAD  (UC_ADDR_ALOAD),
    .UC_ADDR_ASTORE (UC_ADDR_ASTORE)
  ) u_xlate (
    .b0     (h0),
    .b1     (h1),
    .b2     (h2),
    .len    (dec_len),
    .kind   (dec_kind),
    .op     (dec_op),
    .imm    (dec_imm),
    .base   (dec_base),
    .offset (dec_off),
    .uaddr  (dec_uaddr)
  );

  // next-state
  always_comb begin
    fire        = (state_q == ST_RUN) && (held >= CW'(dec_len));
    pop_len     = fire ? dec_len : 2'd0;
    pc_nxt      = pc_q + PC_W'(dec_len);
    valid_nxt   = fire && (dec_kind != K_UCODE);
    illegal_nxt = fire && (dec_kind == K_ILLEGAL);
    ureq_nxt    = fire && (dec_kind == K_UCODE);
    state_nxt   = state_q;
    unique case (state_q)
      ST_RUN:  if (ureq_nxt)   state_nxt = ST_WAIT;
      ST_WAIT: if (ucode_done) state_nxt = ST_RUN;
      default: state_nxt = ST_RUN;
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_RUN;
      pc_q      <= '0;
      valid_q   <= 1'b0;
      illegal_q <= 1'b0;
      ureq_q    <= 1'b0;
    end else begin
      state_q   <= state_nxt;
      valid_q   <= valid_nxt;
      illegal_q <= illegal_nxt;
      ureq_q    <= ureq_nxt;
      if (fire) begin
        pc_q <= pc_nxt;
      end
    end
  end

  // payload registers, loaded only when an instruction is taken
  always_ff @(posedge clk) begin
    if (fire) begin
      op_q    <= dec_op;
      imm_q   <= dec_imm;
      base_q  <= dec_base;
      off_q   <= dec_off;
      ipc_q   <= pc_q;
      uaddr_q <= dec_uaddr;
    end
  end

  assign win_full     = full;
  assign ucode_req    = ureq_q;
  assign ucode_addr   = uaddr_q;
  assign insn_valid   = valid_q;
  assign insn_op      = op_q;
  assign insn_imm     = imm_q;
  assign insn_base    = base_q;
  assign insn_offset  = off_q;
  assign insn_pc      = ipc_q;
  assign insn_illegal = illegal_q;

  assert_ucode_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ucode_req |=> !ucode_req);

  assert_no_issue_with_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ucode_req |-> !insn_valid);

  assert_wait_until_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT && !ucode_done) |=> (state_q == ST_WAIT && !insn_valid));

  assert_illegal_is_nop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    insn_illegal |-> (insn_valid && insn_op == IOP_NOP && insn_base == SEL_NONE
                      && insn_imm == 16'h0000));

  assert_no_accept_when_full_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (win_full && !fire) |=> win_full);

endmodule

// File: tb/bcode_window_dec_tb.sv
`timescale 1ns/1ps
module bcode_window_dec_tb;

  localparam int DEPTH = 8;
  localparam int PC_W  = 16;
  localparam int UA_W  = 8;
  localparam logic [7:0] UA_LD = 8'h10;
  localparam logic [7:0] UA_ST = 8'h20;

  logic            clk, rst_n;
  logic            fetch_valid;
  logic [7:0]      fetch_byte;
  logic            win_full;
  logic            ucode_done;
  logic            ucode_req;
  logic [UA_W-1:0] ucode_addr;
  logic            insn_valid;
  logic [7:0]      insn_op;
  logic [15:0]     insn_imm;
  logic [1:0]      insn_base;
  logic [7:0]      insn_offset;
  logic [PC_W-1:0] insn_pc;
  logic            insn_illegal;

  bcode_window_dec #(.DEPTH(DEPTH), .PC_W(PC_W), .UA_W(UA_W),
                     .UC_ADDR_ALOAD(UA_LD), .UC_ADDR_ASTORE(UA_ST)) u_dut (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_byte(fetch_byte),
    .win_full(win_full), .ucode_done(ucode_done), .ucode_req(ucode_req),
    .ucode_addr(ucode_addr), .insn_valid(insn_valid), .insn_op(insn_op),
    .insn_imm(insn_imm), .insn_base(insn_base), .insn_offset(insn_offset),
    .insn_pc(insn_pc), .insn_illegal(insn_illegal)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  typedef struct {
    bit          uc;
    bit          ill;
    logic [7:0]  op;
    logic [15:0] imm;
    logic [1:0]  base;
    logic [7:0]  off;
    logic [15:0] pc;
    logic [7:0]  ua;
    string       tag;
  } exp_t;

  exp_t       exp_q[$];
  logic [7:0] byte_q[$];
  int         n_cmp = 0;
  int         n_bad = 0;
  logic [15:0] bpc = 16'h0000;
  int         gap = 0;
  bit         want_full = 1'b0;
  bit         done_flag = 1'b0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic ins(input int n, input logic [7:0] b0, input logic [7:0] b1,
                     input logic [7:0] b2, input logic [7:0] op, input logic [15:0] imm,
                     input logic [1:0] base, input logic [7:0] off, input string tag);
    exp_t e;
    e.uc = 0; e.ill = 0; e.op = op; e.imm = imm; e.base = base; e.off = off;
    e.pc = bpc; e.ua = 8'h00; e.tag = tag;
    exp_q.push_back(e);
    bpc = bpc + 16'(n);
    byte_q.push_back(b0);
    if (n > 1) byte_q.push_back(b1);
    if (n > 2) byte_q.push_back(b2);
  endtask

  task automatic bad(input int n, input logic [7:0] b0, input logic [7:0] b1,
                     input string tag);
    exp_t e;
    e.uc = 0; e.ill = 1; e.op = 8'h00; e.imm = 16'h0; e.base = 2'd0; e.off = 8'h0;
    e.pc = bpc; e.ua = 8'h00; e.tag = tag;
    exp_q.push_back(e);
    bpc = bpc + 16'(n);
    byte_q.push_back(b0);
    if (n > 1) byte_q.push_back(b1);
  endtask

  task automatic uc(input logic [7:0] b0, input logic [7:0] ua, input string tag);
    exp_t e;
    e.uc = 1; e.ill = 0; e.op = 8'h00; e.imm = 16'h0; e.base = 2'd0; e.off = 8'h0;
    e.pc = bpc; e.ua = ua; e.tag = tag;
    exp_q.push_back(e);
    bpc = bpc + 16'd1;
    byte_q.push_back(b0);
  endtask

  // driver: one byte per cycle while the window has room
  initial begin
    int gc;
    gc = 0;
    fetch_valid = 1'b0;
    fetch_byte  = 8'h00;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        fetch_valid = 1'b0;
      end else if (gc > 0) begin
        gc--;
        fetch_valid = 1'b0;
      end else if (byte_q.size() > 0 && !win_full) begin
        fetch_valid = 1'b1;
        fetch_byte  = byte_q.pop_front();
        gc = gap;
      end else begin
        fetch_valid = 1'b0;
      end
    end
  end

  // monitor: scoreboard compare
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && (insn_valid || ucode_req)) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R9", "unexpected output", {24'h0, insn_op}, 32'h0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          if (e.uc) begin
            check(ucode_req && !insn_valid, e.tag, "ucode_req",
                  {30'h0, ucode_req, insn_valid}, 32'h2);
            check(ucode_addr == e.ua, e.tag, "ucode_addr", ucode_addr, e.ua);
          end else begin
            check(insn_valid && !ucode_req, e.tag, "valid",
                  {30'h0, insn_valid, ucode_req}, 32'h2);
            check(insn_op == e.op, e.tag, "op", insn_op, e.op);
            check(insn_imm == e.imm, e.tag, "imm", insn_imm, e.imm);
            check(insn_base == e.base, e.tag, "base", insn_base, e.base);
            check(insn_offset == e.off, e.tag, "offset", insn_offset, e.off);
            check(insn_illegal == e.ill, e.tag, "illegal", insn_illegal, e.ill);
            check(insn_pc == e.pc, "R9", "pc", insn_pc, e.pc);
          end
        end
      end
    end
  end

  // microcode sequencer model: hold for a while, then report completion
  initial begin
    ucode_done = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n && ucode_req) begin
        for (int k = 0; k < DEPTH + 4; k++) begin
          @(negedge clk);
          check(!insn_valid && !ucode_req, "R7", "stalled output",
                {30'h0, insn_valid, ucode_req}, 32'h0);
        end
        if (want_full) begin
          check(win_full == 1'b1, "R11", "win_full during stall", win_full, 1);
          want_full = 1'b0;
        end
        ucode_done = 1'b1;
        @(negedge clk);
        ucode_done = 1'b0;
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "R9", "watchdog expired", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(insn_valid == 1'b0, "R1", "insn_valid", insn_valid, 0);
    check(insn_illegal == 1'b0, "R1", "insn_illegal", insn_illegal, 0);
    check(ucode_req == 1'b0, "R1", "ucode_req", ucode_req, 0);
    check(win_full == 1'b0, "R1", "win_full", win_full, 0);

    // R2 / R12: arithmetic, logic, duplicate
    ins(1, 8'h60, 0, 0, 8'h30, 16'h0, 2'd2, 8'd1, "R2");
    ins(1, 8'h64, 0, 0, 8'h31, 16'h0, 2'd2, 8'd1, "R2");
    ins(1, 8'h68, 0, 0, 8'h34, 16'h0, 2'd2, 8'd1, "R2");
    ins(1, 8'h6C, 0, 0, 8'h35, 16'h0, 2'd2, 8'd1, "R2");
    ins(1, 8'h7A, 0, 0, 8'h32, 16'h0, 2'd2, 8'd1, "R2");
    ins(1, 8'h74, 0, 0, 8'hC0, 16'h0, 2'd2, 8'd0, "R12");
    ins(1, 8'h78, 0, 0, 8'hC1, 16'h0, 2'd2, 8'd1, "R2");
    ins(1, 8'h7E, 0, 0, 8'hC3, 16'h0, 2'd2, 8'd1, "R2");
    ins(1, 8'h80, 0, 0, 8'hC4, 16'h0, 2'd2, 8'd1, "R2");
    ins(1, 8'h82, 0, 0, 8'hC5, 16'h0, 2'd2, 8'd1, "R12");
    ins(1, 8'h59, 0, 0, 8'h11, 16'h0, 2'd2, 8'd0, "R12");

    // R3: pushes
    ins(1, 8'h01, 0, 0, 8'h40, 16'h0000, 2'd0, 8'd0, "R3");
    ins(1, 8'h02, 0, 0, 8'h40, 16'hFFFF, 2'd0, 8'd0, "R3");
    ins(1, 8'h03, 0, 0, 8'h40, 16'h0000, 2'd0, 8'd0, "R3");
    ins(1, 8'h08, 0, 0, 8'h40, 16'h0005, 2'd0, 8'd0, "R3");
    ins(2, 8'h10, 8'h80, 0, 8'h40, 16'hFF80, 2'd0, 8'd0, "R3");
    ins(2, 8'h10, 8'h7F, 0, 8'h40, 16'h007F, 2'd0, 8'd0, "R3");
    ins(3, 8'h11, 8'h12, 8'h34, 8'h40, 16'h1234, 2'd0, 8'd0, "R3");

    // R4: local frame accesses
    ins(2, 8'h15, 8'h07, 0, 8'h10, 16'h0, 2'd1, 8'd7, "R4");
    ins(2, 8'h19, 8'h09, 0, 8'h10, 16'h0, 2'd1, 8'd9, "R4");
    ins(1, 8'h1A, 0, 0, 8'h10, 16'h0, 2'd1, 8'd0, "R4");
    ins(1, 8'h1D, 0, 0, 8'h10, 16'h0, 2'd1, 8'd3, "R4");
    ins(1, 8'h2A, 0, 0, 8'h10, 16'h0, 2'd1, 8'd0, "R4");
    ins(1, 8'h2C, 0, 0, 8'h10, 16'h0, 2'd1, 8'd2, "R4");
    ins(2, 8'h36, 8'h05, 0, 8'h20, 16'h0, 2'd1, 8'd5, "R4");
    ins(2, 8'h3A, 8'hFE, 0, 8'h20, 16'h0, 2'd1, 8'hFE, "R4");
    ins(1, 8'h3B, 0, 0, 8'h20, 16'h0, 2'd1, 8'd0, "R4");
    ins(1, 8'h3E, 0, 0, 8'h20, 16'h0, 2'd1, 8'd3, "R4");
    ins(1, 8'h4B, 0, 0, 8'h20, 16'h0, 2'd1, 8'd0, "R4");
    ins(1, 8'h4E, 0, 0, 8'h20, 16'h0, 2'd1, 8'd3, "R4");

    // R5: branches
    ins(3, 8'h99, 8'h00, 8'h10, 8'h50, 16'h0010, 2'd2, 8'd0, "R5");
    ins(3, 8'h9B, 8'hFF, 8'hF0, 8'h59, 16'hFFF0, 2'd2, 8'd0, "R5");
    ins(3, 8'h9F, 8'h00, 8'h08, 8'hA0, 16'h0008, 2'd2, 8'd1, "R5");
    ins(3, 8'hA1, 8'h12, 8'h34, 8'hA9, 16'h1234, 2'd2, 8'd1, "R5");

    // R6: escaped forms
    ins(2, 8'hFF, 8'h04, 0, 8'h11, 16'h0, 2'd2, 8'd0, "R6");
    ins(2, 8'hFF, 8'h24, 0, 8'h21, 16'h0, 2'd2, 8'd1, "R6");
    ins(2, 8'hFF, 8'h40, 0, 8'hF0, 16'h0, 2'd0, 8'd0, "R6");
    ins(2, 8'hFF, 8'h43, 0, 8'hF1, 16'h0, 2'd0, 8'd0, "R6");

    // R8: unknown codes
    bad(2, 8'hFF, 8'h77, "R8");
    bad(1, 8'h84, 0, "R8");
    bad(1, 8'h00, 0, "R8");
    ins(1, 8'h60, 0, 0, 8'h30, 16'h0, 2'd2, 8'd1, "R8");
    bad(1, 8'hCA, 0, "R8");

    // R7 / R11: microcode stall fills the window
    want_full = 1'b1;
    uc(8'h2E, UA_LD, "R7");
    ins(1, 8'h60, 0, 0, 8'h30, 16'h0, 2'd2, 8'd1, "R11");
    ins(1, 8'h64, 0, 0, 8'h31, 16'h0, 2'd2, 8'd1, "R11");
    ins(1, 8'h68, 0, 0, 8'h34, 16'h0, 2'd2, 8'd1, "R11");
    ins(1, 8'h6C, 0, 0, 8'h35, 16'h0, 2'd2, 8'd1, "R11");
    ins(3, 8'h11, 8'hBE, 8'hEF, 8'h40, 16'hBEEF, 2'd0, 8'd0, "R11");
    ins(2, 8'h15, 8'h03, 0, 8'h10, 16'h0, 2'd1, 8'd3, "R11");
    ins(1, 8'h7E, 0, 0, 8'hC3, 16'h0, 2'd2, 8'd1, "R11");
    ins(1, 8'h59, 0, 0, 8'h11, 16'h0, 2'd2, 8'd0, "R11");
    uc(8'h4F, UA_ST, "R7");
    ins(1, 8'h64, 0, 0, 8'h31, 16'h0, 2'd2, 8'd1, "R7");

    wait (exp_q.size() == 0 && byte_q.size() == 0);
    repeat (4) @(negedge clk);

    // R10: bytes trickle in with gaps
    gap = 4;
    ins(3, 8'h11, 8'hAB, 8'hCD, 8'h40, 16'hABCD, 2'd0, 8'd0, "R10");
    ins(2, 8'h10, 8'h05, 0, 8'h40, 16'h0005, 2'd0, 8'd0, "R10");
    ins(3, 8'h9F, 8'h80, 8'h01, 8'hA0, 16'h8001, 2'd2, 8'd1, "R10");
    // partial instruction must not issue
    begin
      int seen;
      seen = 0;
      byte_q.push_back(8'h11);
      byte_q.push_back(8'h55);
      wait (exp_q.size() == 0 && byte_q.size() == 0);
      repeat (12) begin
        @(negedge clk);
        if (insn_valid) seen++;
      end
      check(seen == 0, "R10", "issue with two of three bytes", seen, 0);
      exp_q.push_back('{uc:0, ill:0, op:8'h40, imm:16'h5566, base:2'd0,
                        off:8'd0, pc:bpc, ua:8'h00, tag:"R10"});
      bpc = bpc + 16'd3;
      byte_q.push_back(8'h66);
    end

    wait (exp_q.size() == 0 && byte_q.size() == 0);
    repeat (4) @(negedge clk);
    done_flag = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule